// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters behind one byte-wide register window. A 2-bit address picks either one of the three counter data ports (addresses 0, 1, 2) or a shared command port (address 3). A command byte names the counter it applies to, sets the order in which that counter's bytes move over the bus, picks an output waveform and chooses binary or four-digit BCD counting. A special form of the command takes a snapshot of a running count, so software can read a consistent value over two byte reads.

All counters advance on a shared single-cycle `tick` enable. Each counter has its own `gate` input, which pauses it, and its own `tout` output, which carries the waveform. Four waveforms are built: a level that rises at terminal count, a rate generator with a one-tick low pulse per period, a square wave, and a one-time strobe. A reload value becomes the count on the first enabled tick after the value is complete. To get an output of f Hz from an input rate F, the count is (F + f/2) / f. With the usual 1193182 Hz input, 1000 Hz needs a count of 1193.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every `tout` is 0, every counter and reload value is 0, each counter is in level mode with access type 11 and binary counting, and reading any data port returns 0.
- R2: A counter changes only on a clock edge where `tick` is 1 and its `gate` bit is 1. In level mode and strobe mode it then drops by exactly one. Binary counting wraps from 0 to 0xFFFF.
- R3: A write to address 3 applies to the counter named in bits 7:6 (00, 01, 10). The value 11 is ignored. Bits 3:1 give the mode: 0 is level, 2 is rate, 3 is square, 4 is strobe. Codes 1 and 5 act as 0, and codes 6 and 7 act as 2 and 3. A mode command drives `tout` low in level mode and high in every other mode. Reading address 3 returns 0.
- R4: Bits 5:4 of a command set the access type. 01 means the low byte only (the high byte is cleared on a write). 10 means the high byte only (the low byte is cleared on a write). 11 means the low byte and then the high byte, for writes and for reads, each with its own byte toggle. Any mode command resets both toggles to the low byte. A completed reload value is copied into the counter on the next enabled tick.
- R5: Level mode: `tout` stays low after a load and goes high on the tick that brings the count to 0. It then stays high while counting continues.
- R6: A command with access bits 00 copies the count into a snapshot without changing mode or access type. While the snapshot is held, reads return it, and counting goes on. The snapshot is released after one read (access types 01 and 10) or two reads (access type 11). A second snapshot command before release is ignored. A snapshot command on a ticking edge captures the count before that tick.
- R7: Rate mode: `tout` is low only while the count is 1. The tick after that reloads the count and raises `tout`, so the period is N ticks.
- R8: Square mode: the count drops by one per tick and reloads after 1. `tout` is high while the count is above floor(N/2), so an odd N gives a high phase one tick longer than the low phase.
- R9: Strobe mode: `tout` is high after the command. It drops low for exactly one tick when the count first reaches 0, and the counter then keeps wrapping with no further strobe.
- R10: When bit 0 of the command is 1, the counter decrements in packed four-digit BCD, and 0x0000 wraps to 0x9999.
- R11: A low `gate` freezes the counter. In rate and square modes it also forces `tout` high on the next clock edge, whether or not `tick` is 1.
- R12: In level mode with access type 11, writing the low byte stops counting and drives `tout` low until the high byte completes the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Common count enable, one clock cycle per count step |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; advances the read toggle and the snapshot release |
| bus_addr | input | 2 | 0 to 2 are counter data ports, 3 is the command port |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for the addressed port (combinational) |
| gate | input | 3 | Per-counter count enable, one bit per counter |
| tout | output | 3 | Per-counter waveform output |

## Verification
The key same-cycle collision is a snapshot command arriving on the same clock edge as a count tick. The bench drives the command write and `tick` together for one cycle. It then checks that the two bytes read back hold the count from before the tick, and that the live count read after release is one lower. A second collision is a first-byte write in level mode against a running tick: the bench checks over several later ticks that the count did not move.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DATA_W  = 8;
  localparam int CNT_W   = 2 * DATA_W;
  localparam int NUM_CH  = 3;
  localparam int ADDR_W  = 2;
  localparam int DIGITS  = CNT_W / 4;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    MD_LEVEL  = 3'd0,
    MD_RATE   = 3'd2,
    MD_SQUARE = 3'd3,
    MD_STROBE = 3'd4
  } mode_e;

  typedef struct packed {
    logic  snap;
    acc_e  acc;
    mode_e mode;
    logic  bcd;
  } ctl_cmd_t;

  function automatic mode_e norm_mode(input logic [2:0] raw);
    case (raw)
      3'd2, 3'd6: norm_mode = MD_RATE;
      3'd3, 3'd7: norm_mode = MD_SQUARE;
      3'd4:       norm_mode = MD_STROBE;
      default:    norm_mode = MD_LEVEL;
    endcase
  endfunction

  // Half of a packed BCD value, rounded down
  function automatic logic [CNT_W-1:0] bcd_half(input logic [CNT_W-1:0] v);
    logic       carry;
    logic [3:0] dig;
    bcd_half = '0;
    carry    = 1'b0;
    for (int k = DIGITS - 1; k >= 0; k--) begin
      dig = v[k*4 +: 4];
      bcd_half[k*4 +: 4] = (dig >> 1) + (carry ? 4'd5 : 4'd0);
      carry = dig[0];
    end
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctl_cmd_t          cmd,
  output logic [NUM_CH-1:0] hit
);

  logic [1:0] sel;
  logic [1:0] acc_raw;

  assign sel     = wdata[7:6];
  assign acc_raw = wdata[5:4];

  always_comb begin
    cmd.snap = (acc_raw == 2'b00);
    cmd.acc  = acc_e'(acc_raw);
    cmd.mode = norm_mode(wdata[3:1]);
    cmd.bcd  = wdata[0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign hit[g] = wr_en && (addr == CTL_ADDR) && (sel == 2'(g));
  end

endmodule

// File: rtl/tmr_dec.sv
module tmr_dec
  import tmr_pkg::*;
(
  input  logic [CNT_W-1:0] val,
  input  logic             bcd,
  output logic [CNT_W-1:0] dec
);

  logic [CNT_W-1:0] bcd_dec;

  always_comb begin
    logic borrow;
    borrow  = 1'b1;
    bcd_dec = val;
    for (int k = 0; k < DIGITS; k++) begin
      if (borrow) begin
        if (val[k*4 +: 4] == 4'd0) begin
          bcd_dec[k*4 +: 4] = 4'd9;
        end else begin
          bcd_dec[k*4 +: 4] = val[k*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
  end

  assign dec = bcd ? bcd_dec : (val - CNT_W'(1));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  logic              tick,
  input  logic              gate,
  input  ctl_cmd_t          cmd,
  input  logic              cmd_hit,
  input  logic              dwr,
  input  logic              drd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tout,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [2:0]        mode_o,
  output logic              snap_o,
  output logic [CNT_W-1:0]  snapv_o
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] BIN_FULL = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] BCD_FULL = CNT_W'(5) << (CNT_W - 4);

  mode_e            mode_q, mode_d;
  acc_e             acc_q, acc_d;
  logic             bcd_q, bcd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rel_q, rel_d;
  logic [CNT_W-1:0] snapv_q, snapv_d;
  logic             snap_q, snap_d;
  logic             wflip_q, wflip_d;
  logic             rflip_q, rflip_d;
  logic             armed_q, armed_d;
  logic             ldp_q, ldp_d;
  logic             fired_q, fired_d;
  logic             out_q, out_d;

  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] half;
  logic             run;

  tmr_dec u_dec (
    .val (cnt_q),
    .bcd (bcd_q),
    .dec (dec)
  );

  always_comb begin
    if (rel_q == '0) half = bcd_q ? BCD_FULL : BIN_FULL;
    else             half = bcd_q ? bcd_half(rel_q) : (rel_q >> 1);
  end

  assign run = tick && gate;

  always_comb begin
    logic done;
    mode_d  = mode_q;
    acc_d   = acc_q;
    bcd_d   = bcd_q;
    cnt_d   = cnt_q;
    rel_d   = rel_q;
    snapv_d = snapv_q;
    snap_d  = snap_q;
    wflip_d = wflip_q;
    rflip_d = rflip_q;
    armed_d = armed_q;
    ldp_d   = ldp_q;
    fired_d = fired_q;
    out_d   = out_q;
    done    = 1'b0;

    // counting on an enabled tick
    if (run) begin
      if (ldp_q) begin
        cnt_d   = rel_q;
        ldp_d   = 1'b0;
        armed_d = 1'b1;
        fired_d = 1'b0;
        out_d   = (mode_q != MD_LEVEL);
      end else if (armed_q) begin
        case (mode_q)
          MD_LEVEL: begin
            cnt_d = dec;
            if (dec == '0) out_d = 1'b1;
          end
          MD_STROBE: begin
            cnt_d = dec;
            if (dec == '0 && !fired_q) begin
              out_d   = 1'b0;
              fired_d = 1'b1;
            end else begin
              out_d = 1'b1;
            end
          end
          MD_RATE: begin
            if (cnt_q == ONE) begin
              cnt_d = rel_q;
              out_d = 1'b1;
            end else begin
              cnt_d = dec;
              out_d = (dec != ONE);
            end
          end
          default: begin
            if (cnt_q == ONE) begin
              cnt_d = rel_q;
              out_d = 1'b1;
            end else begin
              cnt_d = dec;
              out_d = (dec > half);
            end
          end
        endcase
      end
    end

    if (!gate && (mode_q == MD_RATE || mode_q == MD_SQUARE)) out_d = 1'b1;

    // data port write
    if (dwr) begin
      case (acc_q)
        ACC_LO: begin
          rel_d = {{(CNT_W-DATA_W){1'b0}}, wdata};
          done  = 1'b1;
        end
        ACC_HI: begin
          rel_d = {wdata, {(CNT_W-DATA_W){1'b0}}};
          done  = 1'b1;
        end
        default: begin
          if (!wflip_q) begin
            rel_d[DATA_W-1:0] = wdata;
            wflip_d = 1'b1;
            if (mode_q == MD_LEVEL) begin
              armed_d = 1'b0;
              ldp_d   = 1'b0;
              out_d   = 1'b0;
            end
          end else begin
            rel_d[CNT_W-1:DATA_W] = wdata;
            wflip_d = 1'b0;
            done    = 1'b1;
          end
        end
      endcase
      if (done) begin
        ldp_d = 1'b1;
        if (mode_q == MD_LEVEL) out_d = 1'b0;
      end
    end

    // data port read
    if (drd) begin
      if (acc_q == ACC_WORD) rflip_d = !rflip_q;
      if (snap_q && (acc_q != ACC_WORD || rflip_q)) snap_d = 1'b0;
    end

    // command
    if (cmd_hit) begin
      if (cmd.snap) begin
        if (!snap_q) begin
          snap_d  = 1'b1;
          snapv_d = cnt_q;
        end
      end else begin
        mode_d  = cmd.mode;
        acc_d   = cmd.acc;
        bcd_d   = cmd.bcd;
        wflip_d = 1'b0;
        rflip_d = 1'b0;
        snap_d  = 1'b0;
        armed_d = 1'b0;
        ldp_d   = 1'b0;
        fired_d = 1'b0;
        out_d   = (cmd.mode != MD_LEVEL);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q  <= MD_LEVEL;
      acc_q   <= ACC_WORD;
      bcd_q   <= 1'b0;
      cnt_q   <= '0;
      rel_q   <= '0;
      snapv_q <= '0;
      snap_q  <= 1'b0;
      wflip_q <= 1'b0;
      rflip_q <= 1'b0;
      armed_q <= 1'b0;
      ldp_q   <= 1'b0;
      fired_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      acc_q   <= acc_d;
      bcd_q   <= bcd_d;
      cnt_q   <= cnt_d;
      rel_q   <= rel_d;
      snapv_q <= snapv_d;
      snap_q  <= snap_d;
      wflip_q <= wflip_d;
      rflip_q <= rflip_d;
      armed_q <= armed_d;
      ldp_q   <= ldp_d;
      fired_q <= fired_d;
      out_q   <= out_d;
    end
  end

  always_comb begin
    logic [CNT_W-1:0] src;
    src = snap_q ? snapv_q : cnt_q;
    case (acc_q)
      ACC_LO:  rdata = src[DATA_W-1:0];
      ACC_HI:  rdata = src[CNT_W-1:DATA_W];
      default: rdata = rflip_q ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
    endcase
  end

  assign tout    = out_q;
  assign cnt_o   = cnt_q;
  assign mode_o  = mode_q;
  assign snap_o  = snap_q;
  assign snapv_o = snapv_q;

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] gate,
  output logic [NUM_CH-1:0] tout
);

  logic                           srst_n;
  ctl_cmd_t                       cmd;
  logic [NUM_CH-1:0]              cmd_hit;
  logic [NUM_CH-1:0][DATA_W-1:0]  ch_rdata;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt;
  logic [NUM_CH-1:0][2:0]         ch_mode;
  logic [NUM_CH-1:0]              ch_snap;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_snapv;
  logic                           ctl_wr;

  assign ctl_wr = bus_wr && (bus_addr == CTL_ADDR);

  tmr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  tmr_ctl_decode u_dec (
    .wr_en (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .cmd   (cmd),
    .hit   (cmd_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel u_ch (
      .clk     (clk),
      .srst_n  (srst_n),
      .tick    (tick),
      .gate    (gate[g]),
      .cmd     (cmd),
      .cmd_hit (cmd_hit[g]),
      .dwr     (bus_wr && (bus_addr == ADDR_W'(g))),
      .drd     (bus_rd && (bus_addr == ADDR_W'(g))),
      .wdata   (bus_wdata),
      .rdata   (ch_rdata[g]),
      .tout    (tout[g]),
      .cnt_o   (ch_cnt[g]),
      .mode_o  (ch_mode[g]),
      .snap_o  (ch_snap[g]),
      .snapv_o (ch_snapv[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(i)) bus_rdata = ch_rdata[i];
    end
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic                          clk,
  input logic                          srst_n,
  input logic                          tick,
  input logic                          ctl_wr,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [NUM_CH-1:0]             gate,
  input logic [NUM_CH-1:0]             tout,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt,
  input logic [NUM_CH-1:0][2:0]        ch_mode,
  input logic [NUM_CH-1:0]             ch_snap,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_snapv
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!srst_n)
      !tick |=> $stable(ch_cnt[g]));

    a_r11_gate_freeze: assert property (@(posedge clk) disable iff (!srst_n)
      !gate[g] |=> $stable(ch_cnt[g]));

    a_r11_gate_out_high: assert property (@(posedge clk) disable iff (!srst_n)
      (!gate[g] && (ch_mode[g] == 3'd2 || ch_mode[g] == 3'd3) && !ctl_wr) |=> tout[g]);

    a_r7_rate_one_tick_low: assert property (@(posedge clk) disable iff (!srst_n)
      (ch_mode[g] == 3'd2 && !tout[g] && tick && gate[g] && !ctl_wr &&
       !(bus_wr && bus_addr == ADDR_W'(g))) |=> tout[g]);

    a_r6_snapshot_frozen: assert property (@(posedge clk) disable iff (!srst_n)
      (ch_snap[g] && !ctl_wr) |=> $stable(ch_snapv[g]));
  end

endmodule

bind tri_interval_timer tmr_checker u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .tick     (tick),
  .ctl_wr   (ctl_wr),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .gate     (gate),
  .tout     (tout),
  .ch_cnt   (ch_cnt),
  .ch_mode  (ch_mode),
  .ch_snap  (ch_snap),
  .ch_snapv (ch_snapv)
);

// File: tb/tri_interval_timer_tb.sv
`timescale 1ns/1ps
module tri_interval_timer_tb;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       bus_wr;
  logic       bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [2:0] gate;
  logic [2:0] tout;

  int n_chk;
  int n_bad;
  bit done;

  tri_interval_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gate      (gate),
    .tout      (tout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 tout after reset", tout, 0);
    rd(2'd0, d); check("R1 ch0 low byte", d, 0);
    rd(2'd0, d); check("R1 ch0 high byte", d, 0);
    rd(2'd2, d); check("R1 ch2 low byte", d, 0);
    rd(2'd3, d); check("R3 control port reads zero", d, 0);
  endtask

  task automatic t_level;
    int v;
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    ticks(1);
    rd16(2'd0, v); check("R4 loaded count", v, 5);
    ticks(4);
    check("R5 tout low before terminal", tout[0], 0);
    ticks(1);
    check("R5 tout high at terminal", tout[0], 1);
    ticks(2);
    rd16(2'd0, v); check("R2 binary wrap", v, 16'hFFFE);
    check("R5 tout stays high", tout[0], 1);
    wr(2'd3, 8'h32);
    check("R3 mode code 1 acts as level", tout[0], 0);
  endtask

  task automatic t_snapshot;
    int v;
    wr(2'd3, 8'h30);
    wr(2'd0, 8'hE8); wr(2'd0, 8'h03);
    ticks(1);
    ticks(10);
    wr(2'd3, 8'h00);
    ticks(5);
    rd16(2'd0, v); check("R6 snapshot value", v, 990);
    rd16(2'd0, v); check("R6 live after release", v, 985);
    wr(2'd3, 8'h00);
    ticks(3);
    wr(2'd3, 8'h00);
    ticks(2);
    rd16(2'd0, v); check("R6 second snapshot ignored", v, 985);
    rd16(2'd0, v); check("R6 counting went on", v, 980);
    // snapshot command on a ticking edge
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h00;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd16(2'd0, v); check("R6 same-edge snapshot pre-tick", v, 980);
    rd16(2'd0, v); check("R2 count after that tick", v, 979);
    check("R6 mode kept (level, tout low)", tout[0], 0);
  endtask

  task automatic t_periodic(input logic [1:0] ch, input logic [7:0] ctl,
                            input int n, input bit square, input string req);
    int c;
    wr(2'd3, ctl);
    wr(ch, 8'(n)); wr(ch, 8'h00);
    ticks(1);
    c = n;
    for (int k = 0; k < 2 * n + 1; k++) begin
      ticks(1);
      if (c == 1) c = n; else c = c - 1;
      check(req, tout[ch], square ? int'(c > n / 2) : int'(c != 1));
    end
  endtask

  task automatic t_strobe;
    int v;
    wr(2'd3, 8'h38);
    check("R9 tout high after command", tout[0], 1);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    ticks(1);
    ticks(2);
    check("R9 high before terminal", tout[0], 1);
    ticks(1);
    check("R9 strobe low at terminal", tout[0], 0);
    ticks(1);
    check("R9 strobe lasts one tick", tout[0], 1);
    ticks(10);
    check("R9 no second strobe", tout[0], 1);
    rd16(2'd0, v); check("R9 keeps wrapping", v, 16'hFFF5);
  endtask

  task automatic t_bcd_and_bytes;
    logic [7:0] d;
    wr(2'd3, 8'h51);
    wr(2'd1, 8'h10);
    ticks(2);
    rd(2'd1, d); check("R10 BCD 10 minus 1", d, 8'h09);
    ticks(9);
    rd(2'd1, d); check("R10 BCD reaches zero", d, 8'h00);
    check("R5 BCD terminal tout", tout[1], 1);
    ticks(1);
    rd(2'd1, d); check("R10 BCD wraps to 9999", d, 8'h99);
    wr(2'd3, 8'h60);
    wr(2'd1, 8'h02);
    ticks(2);
    rd(2'd1, d); check("R4 high-only access", d, 8'h01);
  endtask

  task automatic t_gate;
    int v;
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h04); wr(2'd1, 8'h00);
    ticks(3);
    gate[1] = 1'b0;
    ticks(5);
    rd16(2'd1, v); check("R11 count frozen", v, 2);
    check("R11 tout high while gated", tout[1], 1);
    gate[1] = 1'b1;
    ticks(1);
    check("R7 low at count 1", tout[1], 0);
    gate[1] = 1'b0;
    @(negedge clk);
    check("R11 gate forces high", tout[1], 1);
    gate[1] = 1'b1;
  endtask

  task automatic t_first_byte;
    int v;
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h10); wr(2'd0, 8'h00);
    ticks(3);
    wr(2'd0, 8'h05);
    ticks(3);
    rd16(2'd0, v); check("R12 first byte stops count", v, 16'h0E);
    wr(2'd0, 8'h00);
    ticks(1);
    rd16(2'd0, v); check("R12 new value loaded", v, 5);
    ticks(5);
    check("R12 terminal after reload", tout[0], 1);
  endtask

  task automatic t_toggle_reset;
    int v;
    wr(2'd3, 8'hB0);
    wr(2'd2, 8'h44);
    wr(2'd3, 8'hB0);
    wr(2'd2, 8'h07); wr(2'd2, 8'h00);
    ticks(1);
    rd16(2'd2, v); check("R4 command resets byte toggle", v, 7);
    wr(2'd3, 8'hF0);
    rd16(2'd2, v); check("R3 select 11 ignored", v, 7);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = 2'd0; bus_wdata = 8'h00; gate = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_level();
    t_snapshot();
    t_periodic(2'd1, 8'h74, 4, 1'b0, "R7 rate waveform");
    t_periodic(2'd2, 8'hB6, 5, 1'b1, "R8 square odd");
    t_periodic(2'd2, 8'hB6, 4, 1'b1, "R8 square even");
    t_periodic(2'd1, 8'h7C, 3, 1'b0, "R3 mode code 6 acts as rate");
    t_strobe();
    t_bcd_and_bytes();
    t_gate();
    t_first_byte();
    t_toggle_reset();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      wait (done);
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule